// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This unit takes a processor core into a trap handler. When the trap strobe is high, it works out the final cause value for the trap. It then picks the handling level, supervisor or machine. In the same clock edge it updates the program counter, the level's cause, exception-PC and fault-address registers, the interrupt-enable stack in the status word, and the privilege level.

The surrounding core supplies several inputs each time: the current privilege, the status word, the two delegation masks and the two handler bases. It also supplies the request itself, which is a kind (plain exception, interrupt or address-translation failure) and a code. Every output is held in a register. Outputs keep their values until the next strobe, so a register file can take them back as its new architectural state.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt request (kind 1) produces a cause whose most significant bit is 1 and whose low bits equal the request code.
- R2: An exception request (kind 0) with code 8 is rewritten to 8 plus the current privilege encoding: 8 for user (0), 9 for supervisor (1), 11 for machine (3). Other exception codes pass through unchanged.
- R3: The delegation bit is read from the exception mask for exceptions and from the interrupt mask for interrupts. The bit index is the final cause with the top bit removed. A code of XLEN or more is never delegated.
- R4: The trap goes to supervisor (priv_o = 1) only when the current privilege is 0 or 1 and the delegation bit is set. In every other case it goes to machine (priv_o = 3).
- R5: Supervisor entry does the following:
  - pc_o is the supervisor base with bits 1:0 cleared.
  - scause_o gets the cause and sepc_o gets pc_i.
  - Status bit 5 takes status bit 1, bit 8 takes the old privilege bit 0, and bit 1 is cleared.
  - The machine cause, exception-PC and fault-address registers are unchanged.
- R6: Machine entry does the following:
  - pc_o is the machine base with bits 1:0 cleared.
  - mcause_o gets the cause and mepc_o gets pc_i.
  - Status bit 7 takes status bit 3, bits 12:11 take the old privilege, and bit 3 is cleared.
  - The supervisor cause, exception-PC and fault-address registers are unchanged.
- R7: The target level's fault-address register gets bad_addr_i only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other cause it keeps its value.
- R8: A translation-failure request (kind 2) reads the access type from code bits 1:0: 0 is fetch, 1 is load, and 2 or 3 is store. With paging_on_i high the cause is 12, 13 or 15; with it low the cause is 1, 5 or 7.
- R9: When trap_valid_i is low, every output keeps its value whatever the other inputs do. A strobe takes effect on the next rising clock edge.
- R10: After reset, pc_o, status_o and all cause, exception-PC and fault-address outputs are 0, and priv_o is 3.
- R11: On a trap, status bits other than those named in R5 or R6 are copied from status_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap strobe |
| trap_kind_i | input | 2 | Request kind: 0 exception, 1 interrupt, 2 translation failure |
| trap_code_i | input | CODE_W | Exception code, interrupt number or access type |
| paging_on_i | input | 1 | Address translation active |
| priv_i | input | 2 | Current privilege |
| pc_i | input | XLEN | PC of the trapping instruction |
| bad_addr_i | input | XLEN | Faulting address |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor handler base |
| mtvec_i | input | XLEN | Machine handler base |
| status_i | input | XLEN | Current status word |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | New privilege |
| status_o | output | XLEN | Updated status word |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor fault address |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine fault address |

## Verification
Every output is a register loaded by exactly one strobe, so an error in cause formation, delegation choice or stack update shows up on the ports one edge after the strobe. A wrong held value shows up as a register that changes without a strobe, or as a fault-address register that fails to keep its value. The sweep covers every privilege, both request kinds over the low sixteen codes, and random masks and status words. It compares all nine outputs after every strobe, so a fault is caught at the first trap that exercises it.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    KIND_EXC   = 2'd0,
    KIND_INT   = 2'd1,
    KIND_XLATE = 2'd2
  } kind_e;

  // status word bit positions
  localparam int unsigned ST_SIE    = 1;
  localparam int unsigned ST_MIE    = 3;
  localparam int unsigned ST_SPIE   = 5;
  localparam int unsigned ST_MPIE   = 7;
  localparam int unsigned ST_SPP    = 8;
  localparam int unsigned ST_MPP_LO = 11;
  localparam int unsigned ST_MPP_HI = 12;

  localparam logic [3:0] CODE_ECALL_U = 4'd8;
  localparam logic [15:0] FAULT_CLASS = 16'hB0F3; // 0,1,4-7,12,13,15
endpackage

// File: rtl/trap_cause_gen.sv
module trap_cause_gen
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6
) (
  input  logic [1:0]        kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        priv_i,
  input  logic              paging_on_i,
  output logic [XLEN-1:0]   cause_o,
  output logic [CODE_W-1:0] idx_o,
  output logic              is_int_o,
  output logic              has_tval_o
);
  logic [CODE_W-1:0] code_fin;
  logic [3:0]        xl_code;
  logic              low16;

  always_comb begin
    unique case (code_i[1:0])
      2'd0:    xl_code = paging_on_i ? 4'd12 : 4'd1;
      2'd1:    xl_code = paging_on_i ? 4'd13 : 4'd5;
      default: xl_code = paging_on_i ? 4'd15 : 4'd7;
    endcase
  end

  always_comb begin
    code_fin = code_i;
    if (kind_i == KIND_XLATE)
      code_fin = CODE_W'(xl_code);
    else if (kind_i == KIND_EXC && code_i == CODE_W'(CODE_ECALL_U))
      code_fin = CODE_W'(CODE_ECALL_U + {2'b00, priv_i});
  end

  assign is_int_o = (kind_i == KIND_INT);
  assign idx_o    = code_fin;

  always_comb begin
    cause_o = XLEN'(code_fin);
    cause_o[XLEN-1] = is_int_o;
  end

  generate
    if (CODE_W > 4) begin : g_wide
      assign low16 = ~|code_fin[CODE_W-1:4];
    end else begin : g_narrow
      assign low16 = 1'b1;
    end
  endgenerate

  assign has_tval_o = ~is_int_o & low16 & FAULT_CLASS[code_fin[3:0]];
endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6
) (
  input  logic              is_int_i,
  input  logic [CODE_W-1:0] idx_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  output logic              to_s_o
);
  localparam int unsigned IDX_W = $clog2(XLEN);

  logic [IDX_W-1:0] sel;
  logic             in_range;
  logic [XLEN-1:0]  mask;

  generate
    if (CODE_W > IDX_W) begin : g_trunc
      assign sel      = idx_i[IDX_W-1:0];
      assign in_range = ~|idx_i[CODE_W-1:IDX_W];
    end else begin : g_ext
      assign sel      = IDX_W'(idx_i);
      assign in_range = 1'b1;
    end
  endgenerate

  assign mask   = is_int_i ? mideleg_i : medeleg_i;
  assign to_s_o = ~priv_i[1] & in_range & mask[sel];
endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  logic [1:0]      priv_i,
  input  logic            to_s_i,
  output logic [XLEN-1:0] status_o
);
  always_comb begin
    status_o = status_i;
    if (to_s_i) begin
      status_o[ST_SPIE] = status_i[ST_SIE];
      status_o[ST_SPP]  = priv_i[0];
      status_o[ST_SIE]  = 1'b0;
    end else begin
      status_o[ST_MPIE] = status_i[ST_MIE];
      status_o[ST_MPP_HI:ST_MPP_LO] = priv_i;
      status_o[ST_MIE]  = 1'b0;
    end
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_valid_i,
  input  logic [1:0]        trap_kind_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic              paging_on_i,
  input  logic [1:0]        priv_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   bad_addr_i,
  input  logic [XLEN-1:0]   medeleg_i,
  input  logic [XLEN-1:0]   mideleg_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   status_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o
);
  logic [XLEN-1:0]   cause;
  logic [CODE_W-1:0] idx;
  logic              is_int, has_tval, to_s;
  logic [XLEN-1:0]   status_nx;

  trap_cause_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
    .kind_i      (trap_kind_i),
    .code_i      (trap_code_i),
    .priv_i      (priv_i),
    .paging_on_i (paging_on_i),
    .cause_o     (cause),
    .idx_o       (idx),
    .is_int_o    (is_int),
    .has_tval_o  (has_tval)
  );

  trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_deleg (
    .is_int_i  (is_int),
    .idx_i     (idx),
    .priv_i    (priv_i),
    .medeleg_i (medeleg_i),
    .mideleg_i (mideleg_i),
    .to_s_o    (to_s)
  );

  trap_status_upd #(.XLEN(XLEN)) u_status (
    .status_i (status_i),
    .priv_i   (priv_i),
    .to_s_i   (to_s),
    .status_o (status_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o     <= '0;
      priv_o   <= PRIV_M;
      status_o <= '0;
      scause_o <= '0;
      sepc_o   <= '0;
      stval_o  <= '0;
      mcause_o <= '0;
      mepc_o   <= '0;
      mtval_o  <= '0;
    end else if (trap_valid_i) begin
      status_o <= status_nx;
      if (to_s) begin
        pc_o     <= {stvec_i[XLEN-1:2], 2'b00};
        priv_o   <= PRIV_S;
        scause_o <= cause;
        sepc_o   <= pc_i;
        if (has_tval) stval_o <= bad_addr_i;
      end else begin
        pc_o     <= {mtvec_i[XLEN-1:2], 2'b00};
        priv_o   <= PRIV_M;
        mcause_o <= cause;
        mepc_o   <= pc_i;
        if (has_tval) mtval_o <= bad_addr_i;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_valid_i,
  input logic [1:0]        trap_kind_i,
  input logic [CODE_W-1:0] trap_code_i,
  input logic [1:0]        priv_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   pc_o,
  input logic [1:0]        priv_o,
  input logic [XLEN-1:0]   status_o,
  input logic [XLEN-1:0]   scause_o,
  input logic [XLEN-1:0]   sepc_o,
  input logic [XLEN-1:0]   stval_o,
  input logic [XLEN-1:0]   mcause_o,
  input logic [XLEN-1:0]   mepc_o,
  input logic [XLEN-1:0]   mtval_o
);
  p_int_msb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_kind_i == 2'd1 |=>
      ((priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]));

  p_from_m_stays_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && priv_i == 2'd3 |=> priv_o == 2'd3);

  p_epc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=>
      ((priv_o == 2'd3) ? (mepc_o == $past(pc_i)) : (sepc_o == $past(pc_i))));

  p_pc_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> pc_o[1:0] == 2'b00);

  p_mstack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_o != 2'd3) ||
      (!status_o[3] && status_o[12:11] == $past(priv_i)));

  p_sie_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> (priv_o == 2'd3) || !status_o[1]);

  p_tval_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i && trap_kind_i == 2'd0 && trap_code_i == CODE_W'(2) |=>
      $stable(mtval_o) && $stable(stval_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> $stable(pc_o) && $stable(priv_o) && $stable(status_o) &&
      $stable(scause_o) && $stable(mcause_o) && $stable(sepc_o) &&
      $stable(mepc_o));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_valid_i (trap_valid_i),
  .trap_kind_i  (trap_kind_i),
  .trap_code_i  (trap_code_i),
  .priv_i       (priv_i),
  .pc_i         (pc_i),
  .pc_o         (pc_o),
  .priv_o       (priv_o),
  .status_o     (status_o),
  .scause_o     (scause_o),
  .sepc_o       (sepc_o),
  .stval_o      (stval_o),
  .mcause_o     (mcause_o),
  .mepc_o       (mepc_o),
  .mtval_o      (mtval_o)
);

// File: tb/trap_entry_unit_tb_top.sv
`timescale 1ns/1ps
module trap_entry_unit_tb_top;
  localparam int XLEN   = 32;
  localparam int CODE_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tv = 1'b0;
  logic [1:0]        kind = '0;
  logic [CODE_W-1:0] code = '0;
  logic              pg = 1'b0;
  logic [1:0]        prv = '0;
  logic [XLEN-1:0]   pc = '0, badr = '0, med = '0, mid = '0, stv = '0, mtv = '0, st = '0;
  logic [XLEN-1:0]   pc_o, status_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o;
  logic [1:0]        priv_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [XLEN-1:0] e_pc, e_st, e_sc, e_sepc, e_stv, e_mc, e_mepc, e_mtv;
  logic [1:0]      e_priv;

  always #2.5 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_kind_i(kind),
    .trap_code_i(code), .paging_on_i(pg), .priv_i(prv), .pc_i(pc),
    .bad_addr_i(badr), .medeleg_i(med), .mideleg_i(mid), .stvec_i(stv),
    .mtvec_i(mtv), .status_i(st), .pc_o(pc_o), .priv_o(priv_o),
    .status_o(status_o), .scause_o(scause_o), .sepc_o(sepc_o),
    .stval_o(stval_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctag, input string ttag);
    check(ttag, pc_o, e_pc);
    check("R4", XLEN'(priv_o), XLEN'(e_priv));
    check(ttag, status_o, e_st);
    check(ctag, scause_o, e_sc);
    check(ctag, mcause_o, e_mc);
    check(ttag, sepc_o, e_sepc);
    check(ttag, mepc_o, e_mepc);
    check("R7", stval_o, e_stv);
    check("R7", mtval_o, e_mtv);
  endtask

  // expected values from the requirements
  task automatic do_trap(input logic [1:0] k, input int c, input logic [1:0] p,
                         input bit paging, input logic [XLEN-1:0] dm,
                         input logic [XLEN-1:0] im);
    int fc, ix;
    bit is_int, deleg, to_s, fault;
    logic [XLEN-1:0] cause, s;
    string ctag, ttag;
    is_int = (k == 2'd1);
    fc = c;
    ctag = is_int ? "R1" : "R3";
    if (k == 2'd2) begin
      ctag = "R8";
      case (c % 4)
        0: fc = paging ? 12 : 1;
        1: fc = paging ? 13 : 5;
        default: fc = paging ? 15 : 7;
      endcase
    end else if (!is_int && c == 8) begin
      fc = 8 + int'(p);
      ctag = "R2";
    end
    ix = fc;
    cause = XLEN'(fc);
    if (is_int) cause[XLEN-1] = 1'b1;
    deleg = (ix < XLEN) && (is_int ? im[ix] : dm[ix]);
    to_s = (p <= 2'd1) && deleg;
    fault = !is_int && (ix == 0 || ix == 1 || (ix >= 4 && ix <= 7) ||
                        ix == 12 || ix == 13 || ix == 15);
    pc = $urandom; badr = $urandom; stv = $urandom; mtv = $urandom; st = $urandom;
    s = st;
    if (to_s) begin
      ttag = "R5";
      s[5] = st[1]; s[8] = p[0]; s[1] = 1'b0;
      e_pc = stv & ~XLEN'(3); e_priv = 2'd1; e_sc = cause; e_sepc = pc;
      if (fault) e_stv = badr;
    end else begin
      ttag = "R6";
      s[7] = st[3]; s[12:11] = p; s[3] = 1'b0;
      e_pc = mtv & ~XLEN'(3); e_priv = 2'd3; e_mc = cause; e_mepc = pc;
      if (fault) e_mtv = badr;
    end
    e_st = s;
    kind = k; code = CODE_W'(c); prv = p; pg = paging; med = dm; mid = im;
    tv = 1'b1;
    @(negedge clk);
    tv = 1'b0;
    check_all(ctag, ttag);
    check("R11", status_o & ~XLEN'(32'h19AA), st & ~XLEN'(32'h19AA));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    e_pc = '0; e_st = '0; e_sc = '0; e_sepc = '0; e_stv = '0;
    e_mc = '0; e_mepc = '0; e_mtv = '0; e_priv = 2'd3;
    check_all("R10", "R10");

    // sweep: privilege x kind x code, random masks
    for (int pi = 0; pi < 3; pi++) begin
      for (int k = 0; k < 2; k++) begin
        for (int c = 0; c < 16; c++) begin
          logic [1:0] p;
          p = (pi == 2) ? 2'd3 : 2'(pi);
          do_trap(2'(k), c, p, 1'b0, $urandom, $urandom);
          do_trap(2'(k), c, p, 1'b0, '1, '1);
        end
      end
    end

    // R2: every ecall rewrite, undelegated and delegated
    for (int pi = 0; pi < 3; pi++) begin
      logic [1:0] p;
      p = (pi == 2) ? 2'd3 : 2'(pi);
      do_trap(2'd0, 8, p, 1'b0, '0, '0);
      do_trap(2'd0, 8, p, 1'b0, '1, '0);
    end

    // R8: translation failures, paging on and off
    for (int a = 0; a < 4; a++) begin
      for (int g = 0; g < 2; g++) begin
        do_trap(2'd2, a, 2'd0, g[0], '1, '0);
        do_trap(2'd2, a, 2'd3, g[0], '0, '0);
      end
    end

    // R3: out-of-range codes never delegated; R7: tval kept
    do_trap(2'd0, 33, 2'd0, 1'b0, '1, '1);
    do_trap(2'd1, 40, 2'd1, 1'b0, '1, '1);
    do_trap(2'd0, 5, 2'd1, 1'b0, '0, '1);  // exc mask decides (R3)
    do_trap(2'd1, 5, 2'd1, 1'b0, '1, '0);  // int mask decides (R3)

    // R9: inputs toggle without strobe
    for (int i = 0; i < 8; i++) begin
      kind = 2'(i); code = CODE_W'($urandom); prv = 2'(i); pc = $urandom;
      badr = $urandom; med = $urandom; mid = $urandom; stv = $urandom;
      mtv = $urandom; st = $urandom; pg = i[0];
      @(negedge clk);
      check_all("R9", "R9");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule